// File: doc/BRIEF.md
# Banked Lookup-Table Indirect Access Port

This block holds a family of lookup tables for a video pipeline and gives a host access to all of them through three small registers. There are four table classes: red, green and blue output tables, plus input tables. Each class holds eight selectable tables of 256 eight-bit entries. A control register names the class and the table in use. An index register names the entry. A data window reads or writes that entry.

Apart from the host side, every class has its own pixel lookup port. Each port translates an incoming pixel code through the table currently selected for that class and returns the result one cycle later. The three colour classes share one output-table selector. The input class has its own selector. Host writes and pixel lookups can hit the same entry in the same cycle without stalling either side.

Top module: `lut_access_port`

## Requirements
- R1: After reset the control register and the index register both read back as zero, and `host_rvalid` is low while no read has been issued.
- R2: `host_sel` picks the host target: 0 is the control register, 1 is the index register, 2 is the data window, and 3 is unmapped. A write to 3 changes nothing, and a read of 3 returns zero. The control and index registers read back the last value written.
- R3: Control bits 1:0 choose the class that the data window reaches (0 red, 1 green, 2 blue, 3 input). A data write changes only that class's table, and the same entry in every other class keeps its contents.
- R4: Control bits 4:2 choose one of eight input tables. Control bits 7:5 choose one of eight output tables, and the red, green and blue classes all use that choice.
- R5: The index register keeps its value across data-window reads and writes. It never advances on its own.
- R6: A host read is answered in the next cycle. `host_rvalid` is high for exactly that cycle, and `host_rdata` then holds the value of the target as it was at the time of the read.
- R7: Each pixel port returns, one cycle after its input is presented, the entry that the input code addresses in the table currently selected for that class.
- R8: When a host data write and a pixel lookup address the same entry in the same cycle, the lookup returns the old contents. A lookup of that entry in the next cycle returns the new contents.
- R9: A host read and a host write of the data window in the same cycle read the old contents, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Host target: 0 control, 1 index, 2 data, 3 unmapped |
| host_wdata | input | BUS_W | Host write data |
| host_rdata | output | BUS_W | Host read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | One-cycle flag marking read data |
| pix_r_in | input | IDX_W | Red pixel code |
| pix_g_in | input | IDX_W | Green pixel code |
| pix_b_in | input | IDX_W | Blue pixel code |
| pix_raw_in | input | IDX_W | Raw input pixel code for the input tables |
| pix_r_out | output | DATA_W | Red lookup result |
| pix_g_out | output | DATA_W | Green lookup result |
| pix_b_out | output | DATA_W | Blue lookup result |
| pix_raw_out | output | DATA_W | Input-table lookup result |

## Verification
The assertions check the following on every cycle: the read handshake timing, that the control and index registers hold when they are not written (this covers the no-increment rule), that a control write loads the written value, and that at most one class's table receives a write, and only from a data-window write. The bench scenarios are the only thing that show table contents. These include class isolation, the effect of the table selectors on host and pixel access, old-value returns on collisions, and pixel results under several table settings. The bench compares each of these against its own model of the tables.

// File: rtl/lut_port_pkg.sv
package lut_port_pkg;

  typedef enum logic [1:0] {
    CLS_RED = 2'd0,
    CLS_GRN = 2'd1,
    CLS_BLU = 2'd2,
    CLS_IN  = 2'd3
  } lut_class_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  localparam int NUM_CLASSES = 4;

endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lut_host_regs.sv
module lut_host_regs
  import lut_port_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CTRL_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [BUS_W-1:0]  reg_rdata_q,
  output logic [1:0]        rd_sel_q,
  output lut_class_e        rd_cls_q,
  output logic              rvalid_q
);

  logic              ctrl_en;
  logic              idx_en;
  logic [CTRL_W-1:0] ctrl_d;
  logic [IDX_W-1:0]  idx_d;
  logic [BUS_W-1:0]  rd_val;

  always_comb begin
    ctrl_en = host_wr && (host_sel == SEL_CTRL);
    idx_en  = host_wr && (host_sel == SEL_INDEX);
    ctrl_d  = host_wdata[CTRL_W-1:0];
    idx_d   = host_wdata[IDX_W-1:0];
    rd_val  = '0;
    case (host_sel_e'(host_sel))
      SEL_CTRL:  rd_val[CTRL_W-1:0] = ctrl_q;
      SEL_INDEX: rd_val[IDX_W-1:0]  = idx_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      idx_q       <= '0;
      reg_rdata_q <= '0;
      rd_sel_q    <= '0;
      rd_cls_q    <= CLS_RED;
      rvalid_q    <= 1'b0;
    end else begin
      rvalid_q <= host_rd;
      if (ctrl_en) begin
        ctrl_q <= ctrl_d;
      end
      if (idx_en) begin
        idx_q <= idx_d;
      end
      if (host_rd) begin
        reg_rdata_q <= rd_val;
        rd_sel_q    <= host_sel;
        rd_cls_q    <= lut_class_e'(ctrl_q[1:0]);
      end
    end
  end

endmodule

// File: rtl/lut_bank_ram.sv
module lut_bank_ram #(
  parameter int TBL_W  = 3,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   h_we,
  input  logic                   h_re,
  input  logic [TBL_W+IDX_W-1:0] h_addr,
  input  logic [DATA_W-1:0]      h_wdata,
  output logic [DATA_W-1:0]      h_q,
  input  logic [TBL_W+IDX_W-1:0] p_addr,
  output logic [DATA_W-1:0]      p_q
);

  localparam int AW    = TBL_W + IDX_W;
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write on both ports: same-cycle reads see old contents.
  always_ff @(posedge clk) begin
    if (h_we) begin
      mem[h_addr] <= h_wdata;
    end
    if (h_re) begin
      h_q <= mem[h_addr];
    end
    p_q <= mem[p_addr];
  end

endmodule

// File: rtl/lut_access_port.sv
module lut_access_port
  import lut_port_pkg::*;
#(
  parameter int TBL_W  = 3,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              host_rvalid,
  input  logic [IDX_W-1:0]  pix_r_in,
  input  logic [IDX_W-1:0]  pix_g_in,
  input  logic [IDX_W-1:0]  pix_b_in,
  input  logic [IDX_W-1:0]  pix_raw_in,
  output logic [DATA_W-1:0] pix_r_out,
  output logic [DATA_W-1:0] pix_g_out,
  output logic [DATA_W-1:0] pix_b_out,
  output logic [DATA_W-1:0] pix_raw_out
);

  localparam int CTRL_W = 2 + 2 * TBL_W;
  localparam int AW     = TBL_W + IDX_W;
  localparam int NCLS   = NUM_CLASSES;

  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BUS_W-1:0]  reg_rdata_q;
  logic [1:0]        rd_sel_q;
  lut_class_e        rd_cls_q;
  logic              rvalid_q;

  logic [1:0]        cur_cls;
  logic [TBL_W-1:0]  in_tbl;
  logic [TBL_W-1:0]  out_tbl;
  logic              data_wr;
  logic              data_rd;
  logic [NCLS-1:0]   bank_we;
  logic [NCLS-1:0]   bank_re;
  logic [DATA_W-1:0] bank_hq  [NCLS];
  logic [DATA_W-1:0] bank_pq  [NCLS];
  logic [IDX_W-1:0]  pix_code [NCLS];

  lut_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lut_host_regs #(
    .BUS_W  (BUS_W),
    .CTRL_W (CTRL_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .ctrl_q      (ctrl_q),
    .idx_q       (idx_q),
    .reg_rdata_q (reg_rdata_q),
    .rd_sel_q    (rd_sel_q),
    .rd_cls_q    (rd_cls_q),
    .rvalid_q    (rvalid_q)
  );

  always_comb begin
    cur_cls = ctrl_q[1:0];
    in_tbl  = ctrl_q[2 +: TBL_W];
    out_tbl = ctrl_q[2 + TBL_W +: TBL_W];
    data_wr = host_wr && (host_sel == SEL_DATA);
    data_rd = host_rd && (host_sel == SEL_DATA);
  end

  assign pix_code[CLS_RED] = pix_r_in;
  assign pix_code[CLS_GRN] = pix_g_in;
  assign pix_code[CLS_BLU] = pix_b_in;
  assign pix_code[CLS_IN]  = pix_raw_in;

  for (genvar g = 0; g < NCLS; g++) begin : g_bank
    localparam logic [1:0] CLS_CODE = 2'(g);
    logic [TBL_W-1:0] tsel;

    if (g == int'(CLS_IN)) begin : g_in_sel
      assign tsel = in_tbl;
    end else begin : g_out_sel
      assign tsel = out_tbl;
    end

    assign bank_we[g] = data_wr && (cur_cls == CLS_CODE);
    assign bank_re[g] = data_rd && (cur_cls == CLS_CODE);

    lut_bank_ram #(
      .TBL_W  (TBL_W),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
    ) u_ram (
      .clk     (clk),
      .h_we    (bank_we[g]),
      .h_re    (bank_re[g]),
      .h_addr  ({tsel, idx_q}),
      .h_wdata (host_wdata[DATA_W-1:0]),
      .h_q     (bank_hq[g]),
      .p_addr  (AW'({tsel, pix_code[g]})),
      .p_q     (bank_pq[g])
    );
  end

  always_comb begin
    host_rdata = reg_rdata_q;
    if (rd_sel_q == SEL_DATA) begin
      host_rdata               = '0;
      host_rdata[DATA_W-1:0]   = bank_hq[rd_cls_q];
    end
  end

  assign host_rvalid = rvalid_q;
  assign pix_r_out   = bank_pq[CLS_RED];
  assign pix_g_out   = bank_pq[CLS_GRN];
  assign pix_b_out   = bank_pq[CLS_BLU];
  assign pix_raw_out = bank_pq[CLS_IN];

endmodule

// File: rtl/lut_access_port_chk.sv
module lut_access_port_chk #(
  parameter int BUS_W  = 8,
  parameter int CTRL_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_sel,
  input logic [BUS_W-1:0]  host_wdata,
  input logic              host_rvalid,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic [3:0]        bank_we
);

  // R6
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R6
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == 2'd0) |=> $stable(ctrl_q));

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd0) |=> (ctrl_q == $past(host_wdata[CTRL_W-1:0])));

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == 2'd1) |=> $stable(idx_q));

  // R3
  single_bank_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R3
  bank_we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we != 4'd0) |-> (host_wr && host_sel == 2'd2));

endmodule

bind lut_access_port lut_access_port_chk #(
  .BUS_W  (BUS_W),
  .CTRL_W (CTRL_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_sel    (host_sel),
  .host_wdata  (host_wdata),
  .host_rvalid (host_rvalid),
  .ctrl_q      (ctrl_q),
  .idx_q       (idx_q),
  .bank_we     (bank_we)
);

// File: tb/lut_access_port_bench.sv
`timescale 1ns/100ps
module lut_access_port_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_rd;
  logic [1:0] host_sel;
  logic [7:0] host_wdata, host_rdata;
  logic       host_rvalid;
  logic [7:0] pix_r_in, pix_g_in, pix_b_in, pix_raw_in;
  logic [7:0] pix_r_out, pix_g_out, pix_b_out, pix_raw_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side model of the tables and registers.
  logic [7:0] mdl [int];
  logic [7:0] ctrl_m = 8'h00;
  logic [7:0] idx_m  = 8'h00;
  string      tag_q [$];
  logic [7:0] val_q [$];

  always #2.5 clk = ~clk;

  lut_access_port u_lut_access_port (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .pix_r_in(pix_r_in), .pix_g_in(pix_g_in), .pix_b_in(pix_b_in), .pix_raw_in(pix_raw_in),
    .pix_r_out(pix_r_out), .pix_g_out(pix_g_out), .pix_b_out(pix_b_out), .pix_raw_out(pix_raw_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int key(input int cls, input logic [7:0] code);
    int tbl;
    tbl = (cls == 3) ? int'(ctrl_m[4:2]) : int'(ctrl_m[7:5]);
    return cls * 2048 + tbl * 256 + int'(code);
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] sel);
    case (sel)
      2'd0:    return ctrl_m;
      2'd1:    return idx_m;
      2'd2:    return mdl[key(int'(ctrl_m[1:0]), idx_m)];
      default: return 8'h00;
    endcase
  endfunction

  // Driver: one host operation, expected read value pushed to the scoreboard.
  task automatic host_op(input bit wr, input bit rd, input logic [1:0] sel,
                         input logic [7:0] d, input string tag);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = d;
    if (rd) begin
      tag_q.push_back(tag);
      val_q.push_back(model_read(sel));
    end
    if (wr) begin
      case (sel)
        2'd0:    ctrl_m = d;
        2'd1:    idx_m  = d;
        2'd2:    mdl[key(int'(ctrl_m[1:0]), idx_m)] = d;
        default: ;
      endcase
    end
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    host_op(1'b1, 1'b0, sel, d, "");
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    host_op(1'b0, 1'b1, sel, 8'h00, tag);
  endtask

  task automatic pix_check(input logic [7:0] code, input bit chk_r, input bit chk_g,
                           input bit chk_b, input bit chk_in, input string tag);
    @(negedge clk);
    pix_r_in = code; pix_g_in = code; pix_b_in = code; pix_raw_in = code;
    @(posedge clk); #1;
    if (chk_r)  check({tag, " red"},   pix_r_out,   mdl[key(0, code)]);
    if (chk_g)  check({tag, " green"}, pix_g_out,   mdl[key(1, code)]);
    if (chk_b)  check({tag, " blue"},  pix_b_out,   mdl[key(2, code)]);
    if (chk_in) check({tag, " input"}, pix_raw_out, mdl[key(3, code)]);
  endtask

  // Monitor: pops the scoreboard as read results appear.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (tag_q.size() > 0) begin
        if (!host_rvalid) begin
          checks++; fails++;
          $display("FAIL %s R6 missing rvalid actual=0 expected=1", tag_q[0]);
          void'(tag_q.pop_front()); void'(val_q.pop_front());
        end else begin
          check(tag_q.pop_front(), host_rdata, val_q.pop_front());
        end
      end else if (host_rvalid) begin
        checks++; fails++;
        $display("FAIL R6 stray rvalid actual=1 expected=0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = 0;
    pix_r_in = 0; pix_g_in = 0; pix_b_in = 0; pix_raw_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R1 rvalid idle", {7'd0, host_rvalid}, 8'h00);

    // R1 reset values
    rd(2'd0, "R1 ctrl after reset");
    rd(2'd1, "R1 index after reset");

    // R3 one entry in each class, same index
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h00); wr(2'd2, 8'h11);
    rd(2'd2, "R3 red readback");
    rd(2'd1, "R5 index kept after data access");
    wr(2'd0, 8'h01); wr(2'd2, 8'h22);
    wr(2'd0, 8'h02); wr(2'd2, 8'h33);
    wr(2'd0, 8'h03); wr(2'd2, 8'h44);
    rd(2'd2, "R3 input readback");
    wr(2'd0, 8'h00);
    rd(2'd2, "R3 red untouched by other classes");
    wr(2'd0, 8'h01);
    rd(2'd2, "R3 green untouched");

    // R4 table selectors
    wr(2'd0, 8'h60); wr(2'd2, 8'h55);
    wr(2'd0, 8'h61); wr(2'd2, 8'h77);
    wr(2'd0, 8'h62); wr(2'd2, 8'h88);
    wr(2'd0, 8'h0B); wr(2'd2, 8'h66);
    wr(2'd0, 8'h60);
    rd(2'd2, "R4 red output table 3");
    wr(2'd0, 8'h00);
    rd(2'd2, "R4 red output table 0");
    wr(2'd0, 8'h0B);
    rd(2'd2, "R4 input table 2");
    rd(2'd1, "R5 index still 5");

    // R7 pixel lookups
    wr(2'd0, 8'h00);
    pix_check(8'h05, 1, 1, 1, 1, "R7 tables 0");
    wr(2'd0, 8'h68);
    pix_check(8'h05, 1, 1, 1, 1, "R7 R4 out 3 in 2");
    wr(2'd1, 8'hFE); wr(2'd0, 8'h00); wr(2'd2, 8'hC3);
    pix_check(8'hFE, 1, 0, 0, 0, "R7 top entry");

    // R8 host write and pixel lookup on same entry
    wr(2'd1, 8'h05);
    @(negedge clk);
    pix_r_in = 8'h05; host_wr = 1; host_sel = 2'd2; host_wdata = 8'h99;
    @(posedge clk); #1;
    check("R8 same-cycle lookup old", pix_r_out, 8'h11);
    @(negedge clk); host_wr = 0;
    mdl[key(0, 8'h05)] = 8'h99;
    @(posedge clk); #1;
    check("R8 next lookup new", pix_r_out, 8'h99);

    // R9 read and write same cycle
    host_op(1'b1, 1'b1, 2'd2, 8'hAA, "R9 read old on simultaneous write");
    rd(2'd2, "R9 write took effect");

    // R2 register map
    wr(2'd0, 8'hAB);
    rd(2'd0, "R2 ctrl readback");
    wr(2'd3, 8'hFF);
    rd(2'd0, "R2 ctrl unchanged by unmapped write");
    rd(2'd1, "R2 index unchanged by unmapped write");
    rd(2'd3, "R2 unmapped read zero");

    repeat (3) @(posedge clk);
    #2;
    check("R6 scoreboard drained", 8'(tag_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule